// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Status Flag Generation

This block is the purely combinational execute-stage datapath of a small load/store RISC core. It takes two W-bit operands, the carry bit of the current status register, a 4-bit opcode and a set-flags control. From these it produces a result word, a result-write enable and the four condition flags: negative, zero, carry and overflow. It also produces a flag-write enable. The status register itself lives outside the block and loads the flags when that enable is high.

Every add and subtract variant runs through one shared adder, with the operands swapped or inverted ahead of it. The bitwise operations, bit clear and the two move forms pass through a separate logic unit. For these non-arithmetic operations, the carry flag comes from the barrel shifter's carry output and the overflow flag is the current one, fed back unchanged. The four compare/test opcodes compute a value and flags in the usual way, but never request a register write, and they always request a flag write.

Top module: `alu_nzcv`

## Requirements
- R1: Opcode 4 (add) gives result = A+B modulo 2^W. Opcode 5 (add with carry) gives A+B+carry_in. For both, flag_c is the carry out of bit W-1.
- R2: Opcode 2 (subtract) gives A-B. Opcode 6 (subtract with carry) gives A-B-(1-carry_in). flag_c is 1 exactly when no borrow occurs, i.e. A >= B + (1-carry_in) as unsigned numbers.
- R3: Opcode 3 (reverse subtract) gives B-A. Opcode 7 (reverse subtract with carry) gives B-A-(1-carry_in). flag_c means no borrow, as in R2.
- R4: The logic opcodes give these results: opcode 0 gives A AND B, opcode 1 gives A XOR B, opcode 12 gives A OR B, and opcode 14 (bit clear) gives A AND NOT B.
- R5: Opcode 13 (move) gives result = B. Opcode 15 (move negated) gives NOT B.
- R6: flag_n equals bit W-1 of the computed value. flag_z is 1 exactly when the computed value is all zeros.
- R7: For every add/subtract opcode (2 to 7, 10 and 11), flag_v is 1 exactly when the true signed result does not fit in W bits. For example, 0x7FFFFFFF + 1 gives 0x80000000 with N,Z,C,V = 1,0,0,1.
- R8: For opcodes 0, 1, 8, 9 and 12 to 15, flag_c equals shift_carry and flag_v equals ovf_in.
- R9: The compare/test opcodes compute a value, which appears on result, and flags, but hold result_we at 0 and drive flags_we to 1 whatever set_flags is. They are: 8 (A AND B), 9 (A XOR B), 10 (A-B with subtract flags) and 11 (A+B with add flags).
- R10: For every opcode outside 8 to 11, result_we is 1 and flags_we equals set_flags.
- R11: Adding 0xFFFFFFFF and 1 with opcode 4 gives 0 with N,Z,C,V = 0,1,1,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand |
| op_b | input | W | Second operand, already shifted |
| carry_in | input | 1 | Carry flag of the current status register |
| shift_carry | input | 1 | Carry out of the operand shifter |
| ovf_in | input | 1 | Overflow flag of the current status register |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request to update the status flags |
| result | output | W | Computed value |
| result_we | output | 1 | Destination register write enable |
| flags_we | output | 1 | Status register flag write enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
There is no register between any input and any output, so every result, enable and flag is valid in the same cycle that the stimulus is applied, once the combinational paths settle. The bench changes the inputs on the falling clock edge and samples all outputs one nanosecond later, well before the next rising edge. This keeps every check away from the edge and free of any dependence on process ordering. The expected values come from 64-bit signed and unsigned integer arithmetic written directly from the requirements.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_OR  = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_uses_adder(input alu_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC,
      OP_SBC, OP_RSC, OP_CMP, OP_CMN: op_uses_adder = 1'b1;
      default:                        op_uses_adder = 1'b0;
    endcase
  endfunction

  function automatic logic op_is_compare(input alu_op_e op);
    op_is_compare = (op == OP_TST) || (op == OP_TEQ) ||
                    (op == OP_CMP) || (op == OP_CMN);
  endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import alu_nzcv_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         ci
);

  always_comb begin
    case (op)
      OP_SUB, OP_SBC, OP_CMP: begin x = a; y = ~b; end
      OP_RSB, OP_RSC:         begin x = b; y = ~a; end
      default:                begin x = a; y = b;  end
    endcase
  end

  always_comb begin
    case (op)
      OP_SUB, OP_RSB, OP_CMP: ci = 1'b1;
      OP_ADC, OP_SBC, OP_RSC: ci = cin;
      default:                ci = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  localparam int MSB = W - 1;

  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_nzcv_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lres
);

  always_comb begin
    case (op)
      OP_AND, OP_TST: lres = a & b;
      OP_XOR, OP_TEQ: lres = a ^ b;
      OP_OR:          lres = a | b;
      OP_BIC:         lres = a & ~b;
      OP_MOV:         lres = b;
      OP_MVN:         lres = ~b;
      default:        lres = '0;
    endcase
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_nzcv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  logic         arith,
  input  logic         add_cout,
  input  logic         add_ovf,
  input  logic         shift_carry,
  input  logic         ovf_in,
  output nzcv_t        flags
);

  localparam int MSB = W - 1;

  always_comb begin
    flags.n = value[MSB];
    flags.z = ~|value;
    flags.c = arith ? add_cout : shift_carry;
    flags.v = arith ? add_ovf  : ovf_in;
  end

endmodule

// File: rtl/alu_nzcv.sv
module alu_nzcv
  import alu_nzcv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic         shift_carry,
  input  logic         ovf_in,
  input  logic [3:0]   opcode,
  input  logic         set_flags,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         flags_we,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);

  localparam int MSB = W - 1;

  alu_op_e      op;
  logic [W-1:0] add_x, add_y, add_sum, logic_res;
  logic         add_ci, add_cout, add_ovf;
  logic         arith, cmp;
  nzcv_t        flags;

  assign op    = alu_op_e'(opcode);
  assign arith = op_uses_adder(op);
  assign cmp   = op_is_compare(op);

  alu_operand_sel #(.W(W)) u_sel (
    .op(op), .a(op_a), .b(op_b), .cin(carry_in),
    .x(add_x), .y(add_y), .ci(add_ci)
  );

  alu_addsub #(.W(W)) u_add (
    .x(add_x), .y(add_y), .ci(add_ci),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .op(op), .a(op_a), .b(op_b), .lres(logic_res)
  );

  always_comb begin
    result    = arith ? add_sum : logic_res;
    result_we = ~cmp;
    flags_we  = cmp | set_flags;
  end

  alu_flag_gen #(.W(W)) u_flags (
    .value(result), .arith(arith), .add_cout(add_cout), .add_ovf(add_ovf),
    .shift_carry(shift_carry), .ovf_in(ovf_in), .flags(flags)
  );

  assign flag_n = flags.n;
  assign flag_z = flags.z;
  assign flag_c = flags.c;
  assign flag_v = flags.v;

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in, shift_carry, ovf_in, opcode, set_flags})) begin
      // R9
      cmp_no_write_chk: assert (!(cmp && (result_we || !flags_we)));
      // R8
      logic_flags_pass_chk: assert (arith || (flag_c == shift_carry && flag_v == ovf_in));
      // R2
      sub_carry_chk: assert (op != OP_SUB || flag_c == (op_a >= op_b));
      // R6
      zero_flag_chk: assert (flag_z == (result == '0) && flag_n == result[MSB]);
      // R1
      add_sum_chk: assert (op != OP_ADD || result == op_a + op_b);
    end
  end

endmodule

// File: tb/alu_nzcv_bench.sv
`timescale 1ns/1ps
module alu_nzcv_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] op_a, op_b, result;
  logic        carry_in, shift_carry, ovf_in, set_flags;
  logic [3:0]  opcode;
  logic        result_we, flags_we, flag_n, flag_z, flag_c, flag_v;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  alu_nzcv #(.W(32)) u_alu_nzcv (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .shift_carry(shift_carry),
    .ovf_in(ovf_in), .opcode(opcode), .set_flags(set_flags),
    .result(result), .result_we(result_we), .flags_we(flags_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // Reference values derived from the requirements with 64-bit integers
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic c, input logic sc, input logic vi,
                       output logic [31:0] r, output logic [3:0] nzcv);
    longint ua, ub, sa, sb, u, s, cb;
    logic ec, ev;
    logic ar;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    cb = longint'(c);
    ar = 1'b1; u = 0; s = 0; r = '0;
    case (op)
      4'd4, 4'd11: begin u = ua + ub;          s = sa + sb;          end
      4'd5:        begin u = ua + ub + cb;     s = sa + sb + cb;     end
      4'd2, 4'd10: begin u = ua - ub;          s = sa - sb;          end
      4'd6:        begin u = ua - ub - (1-cb); s = sa - sb - (1-cb); end
      4'd3:        begin u = ub - ua;          s = sb - sa;          end
      4'd7:        begin u = ub - ua - (1-cb); s = sb - sa - (1-cb); end
      default: ar = 1'b0;
    endcase
    if (ar) begin
      r  = u[31:0];
      if (op == 4'd4 || op == 4'd5 || op == 4'd11) ec = (u > 64'sh0FFFF_FFFF);
      else                                        ec = (u >= 0);
      ev = (s > 64'sh7FFF_FFFF) || (s < -64'sh8000_0000);
    end else begin
      case (op)
        4'd0, 4'd8: r = a & b;
        4'd1, 4'd9: r = a ^ b;
        4'd12:      r = a | b;
        4'd14:      r = a & ~b;
        4'd13:      r = b;
        default:    r = ~b;
      endcase
      ec = sc; ev = vi;
    end
    nzcv = {r[31], r == 32'd0, ec, ev};
  endtask

  task automatic check(input string req, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic c, input logic sc,
                       input logic vi, input logic sf);
    logic [31:0] er;
    logic [3:0]  ef;
    logic        ecmp, ewe, efwe;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c; shift_carry = sc; ovf_in = vi;
    opcode = op; set_flags = sf;
    #1;
    model(op, a, b, c, sc, vi, er, ef);
    ecmp = (op >= 4'd8 && op <= 4'd11);
    ewe  = ~ecmp;
    efwe = ecmp | sf;
    tests_run++;
    if (result !== er || {flag_n, flag_z, flag_c, flag_v} !== ef ||
        result_we !== ewe || flags_we !== efwe) begin
      tests_failed++;
      $display("FAIL %s op=%0d: got res=%h nzcv=%b we=%b fwe=%b, exp res=%h nzcv=%b we=%b fwe=%b",
               req, op, result, {flag_n, flag_z, flag_c, flag_v}, result_we, flags_we,
               er, ef, ewe, efwe);
    end
  endtask

  task automatic t_reset;
    check("R5 R6 idle", 4'd13, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_add;
    check("R1", 4'd4, 32'h1234_5678, 32'h1111_1111, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R1", 4'd5, 32'h1234_5678, 32'h1111_1111, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R1", 4'd5, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R11", 4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7", 4'd4, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7", 4'd4, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_sub;
    check("R2", 4'd2, 32'd10, 32'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R2", 4'd2, 32'd3, 32'd10, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R2", 4'd2, 32'd7, 32'd7, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R2", 4'd6, 32'd7, 32'd7, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R2", 4'd6, 32'd7, 32'd7, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7", 4'd2, 32'h8000_0000, 32'd1, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_rsb;
    check("R3", 4'd3, 32'd3, 32'd10, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R3", 4'd3, 32'd10, 32'd3, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3", 4'd7, 32'd4, 32'd9, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R3", 4'd7, 32'd9, 32'd9, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7", 4'd3, 32'd1, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_logic;
    check("R4", 4'd0,  32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R4", 4'd1,  32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R4", 4'd12, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R4", 4'd14, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R8", 4'd0,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R8", 4'd14, 32'h5555_5555, 32'h5555_5555, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_move;
    check("R5", 4'd13, 32'd0, 32'h8000_0001, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R5", 4'd15, 32'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R5", 4'd15, 32'hAAAA_AAAA, 32'h0000_00FF, 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_compare;
    check("R9", 4'd10, 32'd5, 32'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", 4'd10, 32'd4, 32'd5, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R9", 4'd11, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", 4'd8, 32'hF000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R9", 4'd9, 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_flag_gate;
    check("R10", 4'd4,  32'd1, 32'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10", 4'd6,  32'd1, 32'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10", 4'd12, 32'd1, 32'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R10", 4'd15, 32'd1, 32'd2, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; carry_in = 1'b0; shift_carry = 1'b0; ovf_in = 1'b0;
    opcode = 4'd13; set_flags = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_rsb();
    t_logic();
    t_move();
    t_compare();
    t_flag_gate();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: got running, exp finished");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule